// File: doc/BRIEF.md
# Page-Buffered Write Controller

This block is the synchronous control core of a byte-wide nonvolatile memory, with the storage array modelled on chip. A host presents write strobes that carry an address and a data byte. The controller gathers up to 64 bytes that belong to one page in a page latch, and records which byte slots were loaded. When no further byte arrives within a configurable window, the controller runs a self-timed programming period. During that period it commits only the loaded slots to the array.

The host reads the array through a registered read strobe. The busy flag tells the host when a new load period may begin. Both the byte-load window and the programming time are parameters counted in clock cycles. The full device uses a 15-bit address (`ADDR_W = 15`). The default here is smaller so that the modelled array stays compact.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, `busy` is 0 and any half-loaded page is discarded. A reset in the middle of a load period programs nothing.
- R2: A write is accepted only while idle or loading. The first accepted write starts a load period, and `busy` reads 1 from the clock edge after it until the period ends.
- R3: During loading, a byte is accepted if its write strobe is sampled within `LOAD_WIN` cycles of the previous accepted byte. Otherwise, at the `LOAD_WIN`-th cycle with no accepted byte, loading closes and programming starts.
- R4: Byte slots can be loaded in any order. A slot written more than once in one load period ends up with the last value.
- R5: Address bits 5..0 select the slot within a page. Only slots loaded in the current period are written to the array, and every other byte of the page keeps its old value.
- R6: The page (address bits above bit 5) is captured from the first write of a period. A later write with different page bits is dropped, and it does not restart the byte-load window.
- R7: Programming lasts exactly `PROG_CYC` cycles. `busy` falls at the clock edge `LOAD_WIN + PROG_CYC` cycles after the last accepted byte.
- R8: A write is accepted only when `chip_en` = 1, `wr_stb` = 1 and `out_en` = 0. If any of these three conditions fails, no load period starts.
- R9: Write strobes that arrive while programming is in progress are ignored.
- R10: The loaded-slot flags are cleared when programming completes. A later period therefore never re-commits slots loaded in an earlier period.
- R11: A read (`rd_stb` = 1 with `chip_en` = 1) returns the array byte at `addr` on `rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable, active high |
| wr_stb | input | 1 | Write strobe, active high |
| out_en | input | 1 | Output enable, active high; inhibits writes |
| rd_stb | input | 1 | Read strobe, active high |
| addr | input | ADDR_W | Byte address: page bits above slot bits |
| wdata | input | DATA_W | Write data byte |
| rdata | output | DATA_W | Registered read data |
| busy | output | 1 | High from the first accepted byte to the end of programming |

## Verification
The bench aims at the edges of the byte-load window. A byte sampled exactly `LOAD_WIN` cycles after the previous one must land. A byte sampled one cycle later must not: a counter off by one would either lose the first or commit the second. It checks the commit rules by sweeping the whole array. A design that wrote the full page would clobber untouched bytes, one that kept the first value of a rewritten slot would hold a stale byte, and one that kept old slot flags would copy an earlier page's bytes into a later page. Page-mismatch writes, inhibited strobes and writes during programming must leave both the array and the moment `busy` falls exactly as predicted.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pgwr_loadwin.sv
module pgwr_loadwin #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // R3: the idle count never passes the window limit while loading
  p_win_range_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LAST))
    else $error("window counter beyond limit");
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
  parameter int SLOT_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    clr,
  input  logic [SLOT_W-1:0]       rd_slot,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    rd_loaded,
  output logic [(1<<SLOT_W)-1:0]  loaded
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [DATA_W-1:0] buf_q [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) buf_q[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) loaded <= '0;
    else if (wr_en) loaded[wr_slot] <= 1'b1;
  end

  assign rd_data   = buf_q[rd_slot];
  assign rd_loaded = loaded[rd_slot];

  // R4: a slot written this cycle is flagged afterwards
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clr) |=> loaded[$past(wr_slot)])
    else $error("slot flag not set after load");
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 8,
  parameter int SLOT_W   = 6,
  parameter int LOAD_WIN = 15000,
  parameter int PROG_CYC = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en,
  input  logic              wr_stb,
  input  logic              out_en,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int PCNT_W = $clog2(PROG_CYC + SLOTS) + 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(PROG_CYC - 1);
  localparam logic [PCNT_W-1:0] PCNT_WALK = PCNT_W'(SLOTS);

  pg_state_e          state;
  logic [PAGE_W-1:0]  page_q;
  logic [PCNT_W-1:0]  pcnt;

  logic [PAGE_W-1:0]  page_in;
  logic [SLOT_W-1:0]  slot_in;
  logic               wr_ok, accept, win_expired, prog_done;
  logic [SLOT_W-1:0]  walk_slot;
  logic               in_walk, mem_we;
  logic [DATA_W-1:0]  buf_data;
  logic               buf_loaded;
  logic [SLOTS-1:0]   loaded;

  assign page_in = addr[ADDR_W-1:SLOT_W];
  assign slot_in = addr[SLOT_W-1:0];
  assign wr_ok   = chip_en && wr_stb && !out_en;
  assign accept  = wr_ok && ((state == ST_IDLE) ||
                             (state == ST_LOAD && page_in == page_q));

  assign prog_done = (state == ST_PROG) && (pcnt == PCNT_LAST);
  assign walk_slot = pcnt[SLOT_W-1:0];
  assign in_walk   = (state == ST_PROG) && (pcnt < PCNT_WALK);
  assign mem_we    = in_walk && buf_loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      page_q <= '0;
      pcnt   <= '0;
      busy   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_LOAD;
          page_q <= page_in;
          busy   <= 1'b1;
        end
        ST_LOAD: if (!accept && win_expired) begin
          state <= ST_PROG;
          pcnt  <= '0;
        end
        ST_PROG: begin
          pcnt <= pcnt + 1'b1;
          if (prog_done) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgwr_loadwin #(.WIN(LOAD_WIN)) u_win (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .run     (state == ST_LOAD),
    .expired (win_expired)
  );

  pgwr_pagebuf #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (accept),
    .wr_slot   (slot_in),
    .wr_data   (wdata),
    .clr       (prog_done),
    .rd_slot   (walk_slot),
    .rd_data   (buf_data),
    .rd_loaded (buf_loaded),
    .loaded    (loaded)
  );

  pgwr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (mem_we),
    .waddr ({page_q, walk_slot}),
    .wdata (buf_data),
    .re    (rd_stb && chip_en),
    .raddr (addr),
    .rdata (rdata)
  );

  // R2: busy covers the whole load and programming span
  p_busy_span_r2: assert property (@(posedge clk) disable iff (rst)
    busy == (state != ST_IDLE))
    else $error("busy disagrees with controller phase");

  // R5: the array is only written for flagged slots
  p_loaded_only_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> loaded[walk_slot])
    else $error("array write for an unloaded slot");

  // R6: the captured page holds through loading
  p_page_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD) |=> $stable(page_q))
    else $error("page changed during load");

  // R9: no slot gets flagged while programming runs
  p_prog_ignores_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && !prog_done) |=> $stable(loaded))
    else $error("slot flags moved during programming");

  // R10: flags are empty once busy drops
  p_flags_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (loaded == '0))
    else $error("slot flags survive end of programming");
endmodule

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int W  = 8;
  localparam int P  = 70;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en = 1'b0, wr_stb = 1'b0, out_en = 1'b0, rd_stb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DW-1:0] expm [NB];

  always #5 clk = ~clk;

  pgwr_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SLOT_W(6),
              .LOAD_WIN(W), .PROG_CYC(P)) u_dut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .wr_stb(wr_stb),
    .out_en(out_en), .rd_stb(rd_stb), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy));

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input int a, input int d, input logic ce, input logic we, input logic oe);
    chip_en = ce; wr_stb = we; out_en = oe; addr = AW'(a); wdata = DW'(d);
    @(posedge clk);
    @(negedge clk);
    chip_en = 1'b0; wr_stb = 1'b0; out_en = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    strobe(a, d, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while (busy && k < 1000) begin
      idle(1);
      k++;
    end
    chk(!busy, "R7 completion", int'(busy), 0);
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    chip_en = 1'b1; rd_stb = 1'b1; addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    chip_en = 1'b0; rd_stb = 1'b0;
    d = rdata;
  endtask

  task automatic sweep(input string req);
    logic [DW-1:0] d;
    int bad;
    bad = 0;
    for (int a = 0; a < NB; a++) begin
      rd(a, d);
      if (d !== expm[a]) begin
        bad++;
        $display("FAIL %s R11 addr=%0h actual=%0h expected=%0h", req, a, d, expm[a]);
      end
    end
    n_checks++;
    if (bad != 0) n_fails++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);

    // R2/R3: fill every page with back-to-back full-page loads
    for (int p = 0; p < NB / 64; p++) begin
      for (int s = 0; s < 64; s++) begin
        wr(p * 64 + s, pat(p * 64 + s));
        expm[p * 64 + s] = pat(p * 64 + s);
        if (p == 0 && s == 0) chk(busy == 1'b1, "R2 busy after first byte", int'(busy), 1);
      end
      wait_idle();
    end
    sweep("R3 full pages");

    // R7: busy falls exactly LOAD_WIN + PROG_CYC edges after the last byte
    wr(64 + 5, 8'hA1); expm[64 + 5] = 8'hA1;
    idle(W + P - 1);
    chk(busy == 1'b1, "R7 busy before end", int'(busy), 1);
    idle(1);
    chk(busy == 1'b0, "R7 busy at end", int'(busy), 0);

    // R4/R5: out-of-order loading, overwrite, partial page
    wr(128 + 10, 8'h11);
    wr(128 + 3,  8'h22);
    wr(128 + 10, 8'h33);
    wr(128 + 63, 8'h44);
    wr(128 + 0,  8'h55);
    expm[128 + 10] = 8'h33; expm[128 + 3] = 8'h22;
    expm[128 + 63] = 8'h44; expm[128 + 0] = 8'h55;
    wait_idle();
    sweep("R4 R5 order overwrite partial");

    // R3/R9: byte at exactly LOAD_WIN lands, one cycle later is ignored
    wr(192 + 1, 8'h66); expm[192 + 1] = 8'h66;
    idle(W - 1);
    wr(192 + 2, 8'h77); expm[192 + 2] = 8'h77;
    idle(W);
    wr(192 + 3, 8'h88);
    idle(P - 2);
    chk(busy == 1'b1, "R3 R9 busy before end", int'(busy), 1);
    idle(1);
    chk(busy == 1'b0, "R3 R9 busy at end", int'(busy), 0);
    sweep("R3 R9 window edge");

    // R6: mismatched page is dropped and does not extend the window
    wr(7, 8'h99); expm[7] = 8'h99;
    idle(2);
    wr(64 + 7, 8'hBB);
    idle(W + P - 1 - 3);
    chk(busy == 1'b1, "R6 busy before end", int'(busy), 1);
    idle(1);
    chk(busy == 1'b0, "R6 no window restart", int'(busy), 0);
    sweep("R6 page mismatch");

    // R8: inhibited strobes start nothing
    strobe(20, 8'hEE, 1'b1, 1'b1, 1'b1);
    chk(busy == 1'b0, "R8 out_en inhibits", int'(busy), 0);
    strobe(21, 8'hEE, 1'b0, 1'b1, 1'b0);
    chk(busy == 1'b0, "R8 chip_en low inhibits", int'(busy), 0);
    strobe(22, 8'hEE, 1'b1, 1'b0, 1'b0);
    chk(busy == 1'b0, "R8 wr_stb low inhibits", int'(busy), 0);
    idle(W + P + 2);
    sweep("R8 inhibit");

    // R10: flags from one period never leak into the next
    wr(40, 8'hD0); wr(41, 8'hD1);
    expm[40] = 8'hD0; expm[41] = 8'hD1;
    wait_idle();
    wr(192 + 50, 8'hE0); expm[192 + 50] = 8'hE0;
    wait_idle();
    sweep("R10 flags cleared");

    // R1: reset in mid-load discards the page
    wr(64 + 9, 8'h5A);
    idle(2);
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 reset mid-load", int'(busy), 0);
    idle(W + P + 4);
    chk(busy == 1'b0, "R1 stays idle", int'(busy), 0);
    wr(128 + 9, 8'h6B); expm[128 + 9] = 8'h6B;
    wait_idle();
    sweep("R1 reset discards load");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule